// File: doc/BRIEF.md
# Burst SPI Master with Filler Bytes

This block is a register-driven SPI master. Software writes data into a byte-wide transmit queue and sets two counts: the total number of bytes in the burst, and how many of those bytes come from the transmit queue. A single start command then drives the whole burst, with chip select held low from the first bit to the last. Once the transmit count is reached, the master sends 0xFF filler bytes for the rest of the burst. Every byte shifted in from the slave is stored in a receive queue, including bytes that arrive while real data is going out.

A typical use is a flash read. Software queues a command and its address as the transmit bytes, sets the total count to the header plus the payload length, and starts the burst. When the start bit reads back as zero, software pops the receive queue, discarding the header echo bytes and keeping the payload.

The bus is a single-cycle 32-bit register port. Read data is combinational from the address. A read of the receive data offset pops one byte on the clock edge. A write to the transmit data offset pushes its low byte.

Top module: `spi_burst_master`

## Requirements
- R1: After reset, the control, start, clock and status registers read 0, chip select is high, and SCLK is low.
- R2: The following registers read back what was written: control bits 1:0 at 0x04, clock bits 12 and 0 at 0x24, and the 16-bit burst, transmit and lane counts at 0x30, 0x34 and 0x38. The lane count is storage only and does not affect a transfer.
- R3: Writing 1 to bit 31 at 0x08 starts a burst only when control bit 0 (enable) and bit 1 (master) are both set. Otherwise the write is ignored and bit 31 reads 0. Chip select is low only while that bit reads 1.
- R4: SPI mode 0 is used. SCLK idles low, chip select stays low for the whole burst and returns high afterward, and data moves MSB first in both directions.
- R5: Burst byte i takes the head of the transmit queue when i is below the transmit count and the queue is not empty. Otherwise byte i is the filler 0xFF. A byte write to 0x200 pushes bits 7:0.
- R6: Every byte received during a burst is pushed into the receive queue. A read of 0x300 returns it in bits 7:0 and pops it. Status at 0x1C reports the receive level in bits 6:0 and the transmit level in bits 22:16.
- R7: Start bit 31 at 0x08 clears itself when the last byte completes. A start with a burst count of 0 clears it with no chip-select activity.
- R8: A read of 0x300 with an empty receive queue returns 0 and changes no level.
- R9: Each queue holds 64 bytes. A push into a full queue is dropped, so a burst longer than 64 keeps the first 64 received bytes.
- R10: Writing 1 to bit 31 at 0x04 performs a soft reset. It empties both queues, aborts any burst (chip select high, start bit 0), keeps control bits 1:0, and bit 31 clears itself on the next cycle.
- R11: Writing 0x1000 to 0x24 gives an SCLK period of 2 module clocks. Writing 0x1001 gives a period of 4 module clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the receive queue at 0x300) |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the slave |
| spi_miso | input | 1 | Serial data from the slave |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
Bursts are tried with the transmit count equal to the queued bytes, with the transmit count above the queued bytes (the queue runs dry and filler appears early), and with a transmit count of zero (filler only). These cases separate the count-based source choice from a queue-empty check. Random bursts with both divider settings show whether the byte order and bit order follow the slave's pattern and whether the SCLK period follows the clock register. Directed cases cover the corners: a zero-length burst, a start while disabled, a 70-byte burst that overruns the receive queue, an overfilled transmit queue, and a soft reset in the middle of a burst. Each of these ends in a distinct state at the registers and pins.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;
  localparam int unsigned DEF_DEPTH = 64;
  localparam int unsigned DEF_CNT_W = 16;
  localparam logic [7:0]  FILL_BYTE = 8'hFF;

  localparam logic [11:0] OFF_CTRL  = 12'h004;
  localparam logic [11:0] OFF_GO    = 12'h008;
  localparam logic [11:0] OFF_STAT  = 12'h01C;
  localparam logic [11:0] OFF_CLK   = 12'h024;
  localparam logic [11:0] OFF_TOTAL = 12'h030;
  localparam logic [11:0] OFF_TXN   = 12'h034;
  localparam logic [11:0] OFF_LANE  = 12'h038;
  localparam logic [11:0] OFF_TXD   = 12'h200;
  localparam logic [11:0] OFF_RXD   = 12'h300;

  // module clocks per SCLK half period
  function automatic logic [1:0] half_period(input logic div4);
    return div4 ? 2'd2 : 2'd1;
  endfunction

  function automatic logic [7:0] pick_byte(input logic take, input logic [7:0] head);
    return take ? head : FILL_BYTE;
  endfunction
endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned WIDTH = 8,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned LW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic [LW-1:0]    level,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [LW-1:0] count;
  logic do_push, do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == LW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = empty ? '0 : mem[rptr];
  assign level   = count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else if (clr) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= bump(wptr);
      if (do_pop)  rptr <= bump(rptr);
      count <= count + LW'(do_push) - LW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= wdata;
  end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_burst_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             abort,
  input  logic             go,
  input  logic             div4,
  input  logic [CNT_W-1:0] burst,
  input  logic [CNT_W-1:0] txn,
  input  logic [7:0]       tx_head,
  input  logic             tx_empty,
  input  logic             miso,
  output logic             tx_pop,
  output logic             rx_push,
  output logic [7:0]       rx_byte,
  output logic             busy,
  output logic             done,
  output logic             sclk,
  output logic             mosi,
  output logic             cs_n
);
  logic busy_q, sclk_q;
  logic [1:0] half_cnt;
  logic [2:0] bit_idx;
  logic [CNT_W-1:0] byte_idx, load_idx;
  logic [7:0] tx_sh, rx_sh;
  logic launch, empty_burst, tick, byte_end, last_byte, load_now, fetch;

  assign launch      = go && !busy_q && (burst != '0);
  assign empty_burst = go && !busy_q && (burst == '0);
  assign tick        = busy_q && (half_cnt >= half_period(div4) - 2'd1);
  assign byte_end    = tick && sclk_q && (bit_idx == 3'd7);
  assign last_byte   = byte_end && ((byte_idx + 1'b1) == burst);
  assign load_now    = launch || (byte_end && !last_byte);
  assign load_idx    = launch ? '0 : byte_idx + 1'b1;
  assign fetch       = load_now && (load_idx < txn) && !tx_empty;

  assign tx_pop  = fetch;
  assign rx_push = byte_end;
  assign rx_byte = rx_sh;
  assign done    = last_byte || empty_burst;
  assign busy    = busy_q;
  assign sclk    = sclk_q;
  assign mosi    = tx_sh[7];
  assign cs_n    = !busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; sclk_q <= 1'b0; half_cnt <= '0;
      bit_idx <= '0; byte_idx <= '0; tx_sh <= '0; rx_sh <= '0;
    end else if (abort) begin
      busy_q <= 1'b0; sclk_q <= 1'b0; half_cnt <= '0;
      bit_idx <= '0; byte_idx <= '0; tx_sh <= '0; rx_sh <= '0;
    end else if (launch) begin
      busy_q   <= 1'b1;
      sclk_q   <= 1'b0;
      half_cnt <= '0;
      bit_idx  <= '0;
      byte_idx <= '0;
      tx_sh    <= pick_byte(fetch, tx_head);
    end else if (busy_q) begin
      if (!tick) begin
        half_cnt <= half_cnt + 2'd1;
      end else begin
        half_cnt <= '0;
        if (!sclk_q) begin
          sclk_q <= 1'b1;
          rx_sh  <= {rx_sh[6:0], miso};
        end else begin
          sclk_q <= 1'b0;
          if (bit_idx == 3'd7) begin
            bit_idx  <= '0;
            byte_idx <= byte_idx + 1'b1;
            if (last_byte) busy_q <= 1'b0;
            else           tx_sh  <= pick_byte(fetch, tx_head);
          end else begin
            bit_idx <= bit_idx + 3'd1;
            tx_sh   <= {tx_sh[6:0], 1'b0};
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_burst_master.sv
module spi_burst_master
  import spi_burst_pkg::*;
#(
  parameter int unsigned DEPTH = DEF_DEPTH,
  parameter int unsigned CNT_W = DEF_CNT_W,
  localparam int unsigned LW = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [11:0] bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        spi_sclk,
  output logic        spi_mosi,
  input  logic        spi_miso,
  output logic        spi_cs_n
);
  logic en_q, mst_q, srst_q, start_q, clk_sel_q, div4_q;
  logic [CNT_W-1:0] total_q, txn_q, lane_q;
  logic wr_ctrl, go, eng_done, eng_busy;
  logic tx_push, tx_pop, tx_full, tx_empty, rx_push, rx_pop, rx_full, rx_empty;
  logic [7:0] tx_head, rx_head, rx_byte;
  logic [LW-1:0] tx_level, rx_level;

  assign wr_ctrl = bus_wr && (bus_addr == OFF_CTRL);
  assign go      = bus_wr && (bus_addr == OFF_GO) && bus_wdata[31] &&
                   en_q && mst_q && !start_q && !srst_q;
  assign tx_push = bus_wr && (bus_addr == OFF_TXD);
  assign rx_pop  = bus_rd && (bus_addr == OFF_RXD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; mst_q <= 1'b0; srst_q <= 1'b0; start_q <= 1'b0;
      clk_sel_q <= 1'b0; div4_q <= 1'b0;
      total_q <= '0; txn_q <= '0; lane_q <= '0;
    end else begin
      srst_q <= wr_ctrl && bus_wdata[31] && !srst_q;
      if (wr_ctrl) begin
        en_q  <= bus_wdata[0];
        mst_q <= bus_wdata[1];
      end
      if (srst_q)        start_q <= 1'b0;
      else if (eng_done) start_q <= 1'b0;
      else if (go)       start_q <= 1'b1;
      if (bus_wr) begin
        unique case (bus_addr)
          OFF_CLK:   begin clk_sel_q <= bus_wdata[12]; div4_q <= bus_wdata[0]; end
          OFF_TOTAL: total_q <= bus_wdata[CNT_W-1:0];
          OFF_TXN:   txn_q   <= bus_wdata[CNT_W-1:0];
          OFF_LANE:  lane_q  <= bus_wdata[CNT_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (bus_addr)
      OFF_CTRL:  bus_rdata = {srst_q, 29'd0, mst_q, en_q};
      OFF_GO:    bus_rdata = {start_q, 31'd0};
      OFF_STAT:  bus_rdata = 32'(rx_level) | (32'(tx_level) << 16);
      OFF_CLK:   bus_rdata = {19'd0, clk_sel_q, 11'd0, div4_q};
      OFF_TOTAL: bus_rdata = 32'(total_q);
      OFF_TXN:   bus_rdata = 32'(txn_q);
      OFF_LANE:  bus_rdata = 32'(lane_q);
      OFF_RXD:   bus_rdata = {24'd0, rx_head};
      default:   bus_rdata = '0;
    endcase
  end

  spi_byte_fifo #(.DEPTH(DEPTH), .WIDTH(8)) u_tx_fifo (
    .clk(clk), .rst_n(rst_n), .clr(srst_q), .push(tx_push), .wdata(bus_wdata[7:0]),
    .pop(tx_pop), .rdata(tx_head), .level(tx_level), .full(tx_full), .empty(tx_empty));

  spi_byte_fifo #(.DEPTH(DEPTH), .WIDTH(8)) u_rx_fifo (
    .clk(clk), .rst_n(rst_n), .clr(srst_q), .push(rx_push), .wdata(rx_byte),
    .pop(rx_pop), .rdata(rx_head), .level(rx_level), .full(rx_full), .empty(rx_empty));

  spi_shift_engine #(.CNT_W(CNT_W)) u_engine (
    .clk(clk), .rst_n(rst_n), .abort(srst_q), .go(go), .div4(div4_q),
    .burst(total_q), .txn(txn_q), .tx_head(tx_head), .tx_empty(tx_empty),
    .miso(spi_miso), .tx_pop(tx_pop), .rx_push(rx_push), .rx_byte(rx_byte),
    .busy(eng_busy), .done(eng_done), .sclk(spi_sclk), .mosi(spi_mosi), .cs_n(spi_cs_n));
endmodule

// File: rtl/spi_burst_checker.sv
module spi_burst_checker #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned LW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          sclk,
  input logic          mosi,
  input logic          eng_done,
  input logic          srst_q,
  input logic          start_q,
  input logic [LW-1:0] rx_level,
  input logic [LW-1:0] tx_level
);
  assert_sclk_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  assert_mosi_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));

  assert_cs_needs_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> start_q);

  assert_done_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> (cs_n && !start_q));

  assert_srst_selfclear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> !srst_q);

  assert_srst_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> (rx_level == '0 && tx_level == '0 && cs_n));

  assert_level_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level <= LW'(DEPTH)) && (tx_level <= LW'(DEPTH)));
endmodule

bind spi_burst_master spi_burst_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(spi_cs_n), .sclk(spi_sclk), .mosi(spi_mosi),
  .eng_done(eng_done), .srst_q(srst_q), .start_q(start_q),
  .rx_level(rx_level), .tx_level(tx_level));

// File: tb/spi_burst_master_bench.sv
module spi_burst_master_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic spi_sclk, spi_mosi, spi_miso, spi_cs_n;

  int checks = 0, errors = 0;
  bit finished = 0;
  int resp_seed = 0;
  int s_bits = 0;
  logic [7:0] s_in = '0;
  logic [7:0] mosi_log [0:127];
  int cyc = 0, last_rise = 0, last_period = 0, cs_falls = 0;

  always #10 clk = ~clk;

  spi_burst_master u_spi_burst_master (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n));

  function automatic logic [7:0] resp_byte(input int seed, input int k);
    return 8'((k * 73 + seed * 11 + 5) ^ (k >> 1));
  endfunction

  function automatic logic slave_bit(input int seed, input int nbits);
    logic [7:0] b;
    b = resp_byte(seed, nbits / 8);
    return b[7 - (nbits % 8)];
  endfunction

  // slave model: MSB first, mode 0
  assign spi_miso = slave_bit(resp_seed, s_bits);

  always @(posedge spi_sclk or negedge spi_cs_n) begin
    if (!spi_sclk) s_bits = 0;
    else begin
      s_in = {s_in[6:0], spi_mosi};
      s_bits = s_bits + 1;
      if (s_bits % 8 == 0 && s_bits / 8 <= 128) mosi_log[s_bits / 8 - 1] = s_in;
    end
  end

  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge spi_sclk) begin
    last_period = cyc - last_rise;
    last_rise = cyc;
  end
  always @(negedge spi_cs_n) cs_falls = cs_falls + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wait_idle(output bit ok);
    logic [31:0] v;
    ok = 0;
    for (int i = 0; i < 20000; i++) begin
      bus_read(12'h008, v);
      if (!v[31]) begin ok = 1; break; end
    end
  endtask

  task automatic run_burst(input int total, input int txn, input int npush, input bit div4);
    logic [7:0] pushed [0:127];
    logic [31:0] v;
    bit ok;
    int keep;
    bus_write(12'h024, div4 ? 32'h1001 : 32'h1000);
    for (int i = 0; i < npush; i++) begin
      pushed[i] = 8'($urandom);
      bus_write(12'h200, {24'd0, pushed[i]});
    end
    bus_read(12'h01C, v);
    chk("R6 tx level", 32'(v[22:16]), 32'(npush));
    bus_write(12'h030, total);
    bus_write(12'h034, txn);
    bus_write(12'h038, 32'h1);
    resp_seed = int'($urandom % 1000);
    bus_write(12'h008, 32'h8000_0000);
    wait_idle(ok);
    chk("R7 start clears", 32'(ok), 32'd1);
    chk("R4 cs high after", 32'(spi_cs_n), 32'd1);
    for (int i = 0; i < total && i < 128; i++)
      chk("R5 mosi byte", 32'(mosi_log[i]),
          32'((i < txn && i < npush) ? pushed[i] : 8'hFF));
    if (total > 0)
      chk("R11 sclk period", 32'(last_period), div4 ? 32'd4 : 32'd2);
    keep = (total > 64) ? 64 : total;
    bus_read(12'h01C, v);
    chk("R6 rx level", 32'(v[6:0]), 32'(keep));
    chk("R5 tx drained", 32'(v[22:16]), 32'(npush > txn ? npush - txn : 0));
    for (int i = 0; i < keep; i++) begin
      bus_read(12'h300, v);
      chk("R6 rx byte", v, 32'(resp_byte(resp_seed, i)));
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int falls;
    bit ok;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    bus_read(12'h004, v); chk("R1 ctrl", v, 32'h0);
    bus_read(12'h008, v); chk("R1 start", v, 32'h0);
    bus_read(12'h01C, v); chk("R1 status", v, 32'h0);
    bus_read(12'h024, v); chk("R1 clock", v, 32'h0);
    chk("R1 cs_n", 32'(spi_cs_n), 32'd1);
    chk("R1 sclk", 32'(spi_sclk), 32'd0);

    // R3 start while disabled is ignored
    falls = cs_falls;
    bus_write(12'h004, 32'h1);
    bus_write(12'h030, 32'd4);
    bus_write(12'h008, 32'h8000_0000);
    bus_read(12'h008, v); chk("R3 start ignored", v, 32'h0);
    repeat (20) @(negedge clk);
    chk("R3 no cs activity", 32'(cs_falls - falls), 32'd0);

    // R2 readback
    bus_write(12'h004, 32'h3);
    bus_read(12'h004, v); chk("R2 ctrl", v, 32'h3);
    bus_write(12'h024, 32'h1001);
    bus_read(12'h024, v); chk("R2 clock", v, 32'h1001);
    bus_write(12'h030, 32'h1234);
    bus_read(12'h030, v); chk("R2 total", v, 32'h1234);
    bus_write(12'h034, 32'h0056);
    bus_read(12'h034, v); chk("R2 txn", v, 32'h0056);
    bus_write(12'h038, 32'hBEEF);
    bus_read(12'h038, v); chk("R2 lane", v, 32'hBEEF);

    // R8 pop empty
    bus_read(12'h300, v); chk("R8 empty pop", v, 32'h0);
    bus_read(12'h01C, v); chk("R8 levels", v, 32'h0);

    // R7 zero-length burst
    falls = cs_falls;
    bus_write(12'h030, 32'd0);
    bus_write(12'h008, 32'h8000_0000);
    bus_read(12'h008, v); chk("R7 zero burst", v, 32'h0);
    chk("R7 zero burst cs", 32'(cs_falls - falls), 32'd0);

    // R5 directed: queue runs dry, then filler only
    run_burst(6, 4, 2, 1'b0);
    run_burst(5, 0, 0, 1'b1);
    run_burst(4, 4, 4, 1'b1);

    // R9 receive overflow keeps first 64
    run_burst(70, 0, 0, 1'b0);

    // R9 transmit queue full, R10 soft reset empties it
    for (int i = 0; i < 66; i++) bus_write(12'h200, 32'(i));
    bus_read(12'h01C, v); chk("R9 tx cap", 32'(v[22:16]), 32'd64);
    bus_write(12'h004, 32'h8000_0003);
    bus_read(12'h01C, v); chk("R10 levels cleared", v, 32'h0);
    bus_read(12'h004, v); chk("R10 ctrl kept", v, 32'h3);

    // R10 soft reset mid-burst
    bus_write(12'h030, 32'd20);
    bus_write(12'h034, 32'd0);
    bus_write(12'h008, 32'h8000_0000);
    repeat (60) @(negedge clk);
    chk("R4 cs low in burst", 32'(spi_cs_n), 32'd0);
    bus_write(12'h004, 32'h8000_0003);
    bus_read(12'h008, v); chk("R10 abort start", v, 32'h0);
    chk("R10 abort cs", 32'(spi_cs_n), 32'd1);
    bus_read(12'h01C, v); chk("R10 abort rx", v, 32'h0);

    // random bursts
    for (int n = 0; n < 14; n++) begin
      int total, txn, np;
      total = 1 + int'($urandom % 20);
      txn = int'($urandom % (total + 1));
      np = int'($urandom % (txn + 1));
      run_burst(total, txn, np, 1'($urandom));
    end

    wait_idle(ok);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule